// File: doc/BRIEF.md
# EPP Host Parallel Port Controller

This block is the host side of a byte-wide printer-style port. A small CPU register interface offers a data latch, a status view of the peripheral's input pins, a control register and five EPP ports. When no hardware cycle is running, the port behaves as a standard or bidirectional port. The control register drives the four handshake outputs directly, and its direction bit decides whether the 8-bit bus is driven or released.

A CPU write or read at the EPP address port, or at any of the four EPP data ports, starts a hardware-sequenced transfer. The controller marks the direction on `nwrite_o` and waits until the peripheral shows ready by pulling `nwait_i` low. It then asserts the address strobe or the data strobe. It holds that strobe until the peripheral lets `nwait_i` go high. For reads, the bus byte is captured on that acknowledge. If the transfer does not finish within `TIMEOUT_CLKS` clocks, it is abandoned and a sticky timeout flag is raised. A rising edge on the peripheral's interrupt pin can raise a host interrupt when enabled.

All peripheral input pins pass through a `SYNC_STAGES`-deep synchronizer before they reach the status view, the handshake logic or the interrupt detector.

Top module: `epp_host_port`

## Requirements
- R1: Register offsets on `cpu_addr` are: 0 data, 1 status, 2 control, 3 EPP address, 4 to 7 EPP data. After reset the control register reads 0xC4, the timeout flag and `irq_o` are 0, and `cpu_busy` is 0.
- R2: Status reads as: bit 7 = inverted `nwait_i`, bit 6 = `intr_i`, bit 5 = `pe_i`, bit 4 = `slct_i`, bit 3 = `nerror_i`, bits 2 and 1 = 1, bit 0 = timeout flag. The pin values are seen after the synchronizer delay.
- R3: Control bits are: 0 STROBE, 1 AUTOFD, 2 INIT, 3 SLIN, 4 IRQEN, 5 DIR. Bits 7 and 6 read as 1. While idle, `nwrite_o`=~STROBE, `ndstrb_o`=~AUTOFD, `nastrb_o`=~SLIN, `ninit_o`=INIT, `pd_oe`=~DIR and `pd_out` = the data latch.
- R4: A read of offset 0 returns `pd_in` when DIR=1, and returns the data latch when DIR=0.
- R5: An access at offset 3 pulses `nastrb_o` low, and `ndstrb_o` stays high.
- R6: An access at offsets 4 to 7 pulses `ndstrb_o` low, and `nastrb_o` stays high.
- R7: Throughout a transfer, `nwrite_o` is 0 for a CPU write and 1 for a CPU read.
- R8: No strobe is asserted until `nwait_i` is seen low. The strobe is released, and `cpu_busy` falls, once `nwait_i` is seen high.
- R9: Write transfers drive the CPU byte with `pd_oe`=1 for the whole transfer. Read transfers hold `pd_oe`=0, and the `pd_in` byte present at the acknowledge is afterwards returned by reads at offsets 3 to 7.
- R10: A transfer not finished within `TIMEOUT_CLKS` clocks is aborted. `cpu_busy` is high for exactly `TIMEOUT_CLKS` cycles, the strobe is released and the timeout flag is set.
- R11: Writing status with bit 0 = 1 clears the timeout flag, and bit 0 = 0 leaves it set. New transfers run normally while the flag is set.
- R12: EPP accesses made while `cpu_busy` is high are ignored.
- R13: With IRQEN=1, a rising edge on `intr_i` sets `irq_o`. A read strobe at offset 1 clears it. With IRQEN=0, edges leave `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle (side effects only) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| cpu_busy | output | 1 | EPP transfer in progress |
| irq_o | output | 1 | Host interrupt |
| pd_in | input | 8 | Bus value from the pads |
| pd_out | output | 8 | Bus value to the pads |
| pd_oe | output | 1 | Bus output enable |
| nwrite_o | output | 1 | Write/read marker, or inverted STROBE when idle |
| nastrb_o | output | 1 | Address strobe, or inverted SLIN when idle |
| ndstrb_o | output | 1 | Data strobe, or inverted AUTOFD when idle |
| ninit_o | output | 1 | Peripheral initialise, active low |
| nwait_i | input | 1 | Peripheral ready (low) / acknowledge (high) |
| intr_i | input | 1 | Peripheral interrupt / acknowledge pin |
| pe_i | input | 1 | Paper end |
| slct_i | input | 1 | Selected |
| nerror_i | input | 1 | Error, active low |

## Verification
A sequencer stuck in a waiting state shows up as `cpu_busy` staying high until the timeout. The bench measures that length exactly and compares it with `TIMEOUT_CLKS`. A strobe decoded from the wrong offset, or a wrong direction marker, is visible at the pins within the first transfer, because a responder model logs every strobe cycle together with the bus enable and the byte. Faults in the flags are caught within a few cycles at `irq_o`, or on the next status read.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam logic [2:0] OFS_DATA     = 3'd0;
    localparam logic [2:0] OFS_STATUS   = 3'd1;
    localparam logic [2:0] OFS_CTRL     = 3'd2;
    localparam logic [2:0] OFS_EPP_ADDR = 3'd3;

    typedef struct packed {
        logic dir;
        logic irqen;
        logic slin;
        logic init;
        logic autofd;
        logic strobe;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{dir: 1'b0, irqen: 1'b0, slin: 1'b0,
                                     init: 1'b1, autofd: 1'b0, strobe: 1'b0};

    typedef struct packed {
        logic nwait;
        logic intr;
        logic pe;
        logic slct;
        logic nerror;
    } pin_in_t;

    typedef struct packed {
        logic       is_addr;
        logic       is_write;
        logic [7:0] data;
    } cyc_req_t;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_WAIT_RDY,
        CYC_STROBE
    } cyc_state_e;

    function automatic logic [7:0] status_byte(pin_in_t p, logic tmo);
        return {~p.nwait, p.intr, p.pe, p.slct, p.nerror, 2'b11, tmo};
    endfunction

    function automatic logic [7:0] ctrl_byte(ctrl_t c);
        return {2'b11, c};
    endfunction

    function automatic logic is_epp_ofs(logic [2:0] a);
        return a >= OFS_EPP_ADDR;
    endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_cycle.sv
module epp_cycle
    import epp_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cyc_req_t   req_in,
    input  logic       nwait_s,
    input  logic [7:0] pd_in,
    output logic       busy,
    output logic       strobe_on,
    output cyc_req_t   cur,
    output logic [7:0] rd_buf,
    output logic       tmo_set
);
    localparam int CNT_W = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CLKS - 1);

    cyc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             acked;

    assign busy      = (state != CYC_IDLE);
    assign strobe_on = (state == CYC_STROBE);
    assign acked     = strobe_on && nwait_s;
    assign tmo_set   = busy && (cnt == LIMIT) && !acked;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CYC_IDLE;
            cnt    <= '0;
            cur    <= '0;
            rd_buf <= '0;
        end else begin
            case (state)
                CYC_IDLE: begin
                    if (start) begin
                        cur   <= req_in;
                        cnt   <= '0;
                        state <= CYC_WAIT_RDY;
                    end
                end
                CYC_WAIT_RDY: begin
                    if (cnt == LIMIT) begin
                        state <= CYC_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (!nwait_s) state <= CYC_STROBE;
                    end
                end
                CYC_STROBE: begin
                    if (nwait_s) begin
                        state <= CYC_IDLE;
                        if (!cur.is_write) rd_buf <= pd_in;
                    end else if (cnt == LIMIT) begin
                        state <= CYC_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end

    // R8: a strobe only begins after ready was observed
    assert_strobe_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_on) |-> $past(!nwait_s));
    // R8: acknowledge ends the transfer on the next cycle
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
        acked |=> !busy);
    // R10: counter never passes the window
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
    // R10: timeout abandons the transfer
    assert_timeout_release_R10: assert property (@(posedge clk) disable iff (rst)
        tmo_set |=> !busy);
endmodule

// File: rtl/epp_regs.sv
module epp_regs
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    input  pin_in_t    pins_s,
    input  logic [7:0] pd_in,
    input  logic       busy,
    input  logic       tmo_set,
    input  logic [7:0] rd_buf,
    output logic [7:0] cpu_rdata,
    output ctrl_t      ctrl,
    output logic [7:0] data_q,
    output logic       irq,
    output logic       start,
    output cyc_req_t   req
);
    logic tmo_q;
    logic intr_prev;
    logic irq_set;
    logic stat_rd;

    assign start       = (cpu_wr || cpu_rd) && is_epp_ofs(cpu_addr) && !busy;
    assign req.is_addr = (cpu_addr == OFS_EPP_ADDR);
    assign req.is_write = cpu_wr;
    assign req.data    = cpu_wdata;

    assign irq_set = ctrl.irqen && pins_s.intr && !intr_prev;
    assign stat_rd = cpu_rd && (cpu_addr == OFS_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RESET;
            data_q    <= '0;
            tmo_q     <= 1'b0;
            intr_prev <= 1'b0;
            irq       <= 1'b0;
        end else begin
            intr_prev <= pins_s.intr;
            if (cpu_wr && cpu_addr == OFS_DATA) data_q <= cpu_wdata;
            if (cpu_wr && cpu_addr == OFS_CTRL) ctrl <= ctrl_t'(cpu_wdata[5:0]);
            if (tmo_set)
                tmo_q <= 1'b1;
            else if (cpu_wr && cpu_addr == OFS_STATUS && cpu_wdata[0])
                tmo_q <= 1'b0;
            if (irq_set)      irq <= 1'b1;
            else if (stat_rd) irq <= 1'b0;
        end
    end

    always_comb begin
        case (cpu_addr)
            OFS_DATA:   cpu_rdata = ctrl.dir ? pd_in : data_q;
            OFS_STATUS: cpu_rdata = status_byte(pins_s, tmo_q);
            OFS_CTRL:   cpu_rdata = ctrl_byte(ctrl);
            default:    cpu_rdata = rd_buf;
        endcase
    end

    // R10: a timeout always leaves the flag set
    assert_tmo_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        tmo_set |=> tmo_q);
    // R13: status read with no new edge clears the interrupt
    assert_irq_clear_R13: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !irq_set) |=> !irq);
    // R13: disabled interrupts never rise
    assert_irq_masked_R13: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.irqen && !irq) |=> !irq);
endmodule

// File: rtl/epp_host_port.sv
module epp_host_port
    import epp_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       cpu_busy,
    output logic       irq_o,
    input  logic [7:0] pd_in,
    output logic [7:0] pd_out,
    output logic       pd_oe,
    output logic       nwrite_o,
    output logic       nastrb_o,
    output logic       ndstrb_o,
    output logic       ninit_o,
    input  logic       nwait_i,
    input  logic       intr_i,
    input  logic       pe_i,
    input  logic       slct_i,
    input  logic       nerror_i
);
    localparam int PIN_W = $bits(pin_in_t);

    pin_in_t          pins_raw;
    pin_in_t          pins_s;
    logic [PIN_W-1:0] pins_sync;
    ctrl_t            ctrl;
    logic [7:0]       data_q;
    logic [7:0]       rd_buf;
    logic             start;
    logic             tmo_set;
    logic             strobe_on;
    cyc_req_t         req;
    cyc_req_t         cur;

    assign pins_raw = '{nwait: nwait_i, intr: intr_i, pe: pe_i,
                        slct: slct_i, nerror: nerror_i};
    assign pins_s   = pin_in_t'(pins_sync);

    epp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_sync)
    );

    epp_regs u_regs (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .pins_s(pins_s),
        .pd_in(pd_in), .busy(cpu_busy), .tmo_set(tmo_set), .rd_buf(rd_buf),
        .cpu_rdata(cpu_rdata), .ctrl(ctrl), .data_q(data_q), .irq(irq_o),
        .start(start), .req(req)
    );

    epp_cycle #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_cycle (
        .clk(clk), .rst(rst), .start(start), .req_in(req),
        .nwait_s(pins_s.nwait), .pd_in(pd_in), .busy(cpu_busy),
        .strobe_on(strobe_on), .cur(cur), .rd_buf(rd_buf), .tmo_set(tmo_set)
    );

    always_comb begin
        ninit_o = ctrl.init;
        if (cpu_busy) begin
            nwrite_o = !cur.is_write;
            nastrb_o = !(strobe_on && cur.is_addr);
            ndstrb_o = !(strobe_on && !cur.is_addr);
            pd_oe    = cur.is_write;
            pd_out   = cur.is_write ? cur.data : data_q;
        end else begin
            nwrite_o = !ctrl.strobe;
            nastrb_o = !ctrl.slin;
            ndstrb_o = !ctrl.autofd;
            pd_oe    = !ctrl.dir;
            pd_out   = data_q;
        end
    end

    // R5 / R6: never both strobes during a transfer
    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_busy |-> (nastrb_o || ndstrb_o));
    // R9: read transfers release the bus
    assert_read_tristate_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_busy && nwrite_o) |-> !pd_oe);
    // R7: direction marker holds for the whole transfer
    assert_dir_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_busy && $past(cpu_busy)) |-> $stable(nwrite_o));
endmodule

// File: tb/tb_epp_host_port.sv
`timescale 1ns/1ps
module tb_epp_host_port;
    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_busy, irq_o;
    logic [7:0] pd_in = '0;
    logic [7:0] pd_out;
    logic       pd_oe, nwrite_o, nastrb_o, ndstrb_o, ninit_o;
    logic       nwait_i = 1'b0, intr_i = 1'b0, pe_i = 1'b1, slct_i = 1'b1, nerror_i = 1'b1;

    epp_host_port #(.TIMEOUT_CLKS(TMO), .SYNC_STAGES(2)) dut (.*);

    always #10 clk = ~clk;

    int vectors = 0, errors = 0;
    bit finished = 0;

    // responder: 0 auto-ack, 1 never ready, 2 ready but never ack, 3 passive ready
    int pmode = 3;
    logic [7:0] resp = '0;
    int ack_cnt = 0;
    int n_astrb, n_dstrb, n_wr_low, n_wr_high, n_oe0, n_oe1, n_episodes;
    logic [7:0] last_pd;
    bit prev_strb = 0;

    task automatic clear_log();
        n_astrb = 0; n_dstrb = 0; n_wr_low = 0; n_wr_high = 0;
        n_oe0 = 0; n_oe1 = 0; n_episodes = 0; last_pd = '0;
    endtask

    task automatic periph_loop();
        forever begin
            bit strb;
            @(negedge clk);
            strb = cpu_busy && (!nastrb_o || !ndstrb_o);
            if (strb) begin
                if (!nastrb_o) n_astrb++;
                if (!ndstrb_o) n_dstrb++;
                if (nwrite_o) n_wr_high++; else n_wr_low++;
                if (pd_oe) begin n_oe1++; last_pd = pd_out; end else n_oe0++;
                if (!prev_strb) n_episodes++;
            end
            prev_strb = strb;
            case (pmode)
                0: if (strb) begin
                       ack_cnt++;
                       if (ack_cnt >= 3) begin nwait_i = 1'b1; pd_in = resp; end
                   end else begin
                       ack_cnt = 0; nwait_i = 1'b0;
                   end
                1: nwait_i = 1'b1;
                default: nwait_i = 1'b0;
            endcase
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic rd_pulse(input logic [2:0] a);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); cpu_addr = a; #1 v = cpu_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cpu_busy && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(2, v); chk("R1 ctrl reset", v, 8'hC4);
        rd_reg(1, v); chk("R1/R2 status reset", v, 8'hBE);
        chk("R1 irq reset", irq_o, 0);
        chk("R1 busy reset", cpu_busy, 0);
        chk("R3 idle pins reset", {ninit_o, nwrite_o, nastrb_o, ndstrb_o, pd_oe}, 5'b11111);
    endtask

    task automatic t_status();
        logic [7:0] v;
        pmode = 1; intr_i = 1; pe_i = 0; slct_i = 1; nerror_i = 0;
        repeat (4) @(negedge clk);
        rd_reg(1, v); chk("R2 status pattern", v, 8'h56);
        pmode = 3; intr_i = 0; pe_i = 1; nerror_i = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_spp();
        logic [7:0] v;
        wr_reg(2, 8'h2B);
        rd_reg(2, v); chk("R3 ctrl readback", v, 8'hEB);
        chk("R3 idle pins follow ctrl", {ninit_o, nwrite_o, nastrb_o, ndstrb_o, pd_oe}, 5'b00000);
        pd_in = 8'h3C;
        rd_reg(0, v); chk("R4 data read DIR=1", v, 8'h3C);
        wr_reg(0, 8'h81);
        wr_reg(2, 8'h04);
        rd_reg(0, v); chk("R4 data read DIR=0", v, 8'h81);
        chk("R3 pd driven from latch", {pd_oe, pd_out}, {1'b1, 8'h81});
    endtask

    task automatic t_addr_write();
        int n;
        clear_log(); pmode = 0;
        wr_reg(3, 8'hA5); wait_idle(n);
        chk("R5 address strobe used", n_astrb > 0, 1);
        chk("R5 data strobe idle", n_dstrb, 0);
        chk("R7 nwrite low on write", n_wr_high, 0);
        chk("R9 write drives bus", {n_oe0 == 0, last_pd}, {1'b1, 8'hA5});
        chk("R8 single handshake", n_episodes, 1);
    endtask

    task automatic t_data_read();
        int n; logic [7:0] v;
        clear_log(); pmode = 0; resp = 8'h5A;
        rd_pulse(6); wait_idle(n);
        chk("R6 data strobe used", n_dstrb > 0, 1);
        chk("R6 address strobe idle", n_astrb, 0);
        chk("R7 nwrite high on read", n_wr_low, 0);
        chk("R9 read releases bus", n_oe1, 0);
        rd_reg(6, v); chk("R9 read byte captured", v, 8'h5A);
    endtask

    task automatic t_more_cycles();
        int n; logic [7:0] v;
        clear_log(); pmode = 0;
        wr_reg(7, 8'h3C); wait_idle(n);
        chk("R6 data write offset 7", {n_dstrb > 0, n_astrb == 0, last_pd}, {2'b11, 8'h3C});
        clear_log(); resp = 8'hC3;
        rd_pulse(3); wait_idle(n);
        rd_reg(3, v);
        chk("R5 address read", {n_astrb > 0, n_wr_low == 0, v}, {2'b11, 8'hC3});
    endtask

    task automatic t_ignore_busy();
        int n;
        clear_log(); pmode = 1;
        repeat (3) @(negedge clk);
        wr_reg(4, 8'h11);
        wr_reg(5, 8'h22);
        chk("R8 no strobe before ready", n_astrb + n_dstrb, 0);
        pmode = 0;
        wait_idle(n);
        chk("R12 second access ignored", {n_episodes[7:0], last_pd}, {8'd1, 8'h11});
        repeat (4) @(negedge clk);
        chk("R12 no follow-on transfer", cpu_busy, 0);
    endtask

    task automatic t_timeout();
        int n; logic [7:0] v;
        clear_log(); pmode = 1;
        repeat (3) @(negedge clk);
        wr_reg(4, 8'h99); wait_idle(n);
        chk("R10 busy window never-ready", n, TMO);
        chk("R8 never strobed", n_astrb + n_dstrb, 0);
        rd_reg(1, v); chk("R10 TMOUT set", v[0], 1);
        pmode = 2; clear_log();
        repeat (3) @(negedge clk);
        wr_reg(5, 8'h77); wait_idle(n);
        chk("R10 busy window no-ack", n, TMO);
        chk("R10 strobe released", {n_dstrb > 0, ndstrb_o}, 2'b11);
        wr_reg(1, 8'h00);
        rd_reg(1, v); chk("R11 zero write keeps TMOUT", v[0], 1);
        pmode = 0; clear_log();
        wr_reg(4, 8'h42); wait_idle(n);
        chk("R11 transfer while TMOUT set", {n < TMO, last_pd}, {1'b1, 8'h42});
        wr_reg(1, 8'h01);
        rd_reg(1, v); chk("R11 TMOUT cleared", v[0], 0);
    endtask

    task automatic t_irq();
        wr_reg(2, 8'h04);
        intr_i = 1; repeat (6) @(negedge clk);
        chk("R13 masked edge", irq_o, 0);
        intr_i = 0; repeat (4) @(negedge clk);
        wr_reg(2, 8'h14);
        intr_i = 1; repeat (6) @(negedge clk);
        chk("R13 enabled edge raises irq", irq_o, 1);
        rd_pulse(1); #1;
        chk("R13 status read clears irq", irq_o, 0);
        intr_i = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial periph_loop();

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_status();
        t_spp();
        t_addr_write();
        t_data_read();
        t_more_cycles();
        t_ignore_busy();
        t_timeout();
        t_irq();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule